// File: doc/BRIEF.md
# Byte-Exchange SPI Master with Register Port

This block is a bus-attached SPI master. It exchanges a programmable number of bits with one SPI device. Software first loads a transmit byte and a clock divider. It then writes a control word that holds a start bit and a bit count. While the block shifts the transmit byte out on MOSI, it captures MISO into the same shift register, so every transfer is full-duplex. When the last bit is in, the block sets a done flag and copies the received byte into a readable register. Software learns that the transfer has finished only by polling the done flag.

SCLK idles low. MOSI presents the next bit while SCLK is low and changes only when SCLK falls. MISO is captured when SCLK rises. Each SCLK phase lasts the programmed number of system clocks. Chip select is driven from a register bit that software controls. The register port is a plain address, write-enable and write-data interface, and a registered read path returns data one cycle after the address is presented.

Top module: `spi_byte_master`

## Requirements
- R1: After reset, `spi_cs_n` is 1, `spi_sclk` is 0, and the status, receive, transmit, divider, control and select registers all read 0.
- R2: The registers sit at byte offsets 0x00 (transmit byte, bits [7:0], read/write), 0x04 (receive byte, bits [7:0], read-only), 0x08 (control), 0x0C (status), 0x10 (divider, bits [15:0], read/write) and 0x14 (select, bit 0). Bits above a register's field are not stored and read as 0.
- R3: A control write with bit 0 set and a nonzero count in bits [15:8] starts a transfer of that many bits. A write with bit 0 clear or a count of 0 starts nothing. The control register reads back the last written count in bits [15:8].
- R4: SCLK is low when idle. MOSI carries the transmit byte most-significant bit first and changes only while SCLK is low. MISO is sampled on the SCLK rising edge.
- R5: After an N-bit transfer with 1 ≤ N ≤ 8, the receive register holds the transmit byte shifted left by N, with the N received bits in the low positions. After 8 bits it holds exactly the received byte. Longer transfers keep shifting through the same 8-bit register.
- R6: Status bit 0 (done) clears in the cycle that a transfer is accepted. It stays 0 until the last bit has been sampled and SCLK has returned low, and it then reads 1.
- R7: Each SCLK phase lasts D system clocks, where D is the divider value and a value of 0 counts as 1. An N-bit transfer therefore sets done 2·D·N clocks after the start write.
- R8: A start request made while a transfer is running is ignored. A transmit-byte write made during a transfer does not change the bits already being sent.
- R9: Writing 1 to bit 0 of the select register drives `spi_cs_n` low, and writing 0 drives it high.
- R10: `bus_rdata` shows the register addressed in the cycle before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 5 | Byte address of the register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| spi_cs_n | output | 1 | Device select, active low |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the device |
| spi_miso | input | 1 | Serial data from the device |

## Verification
The hardest case to reach is a second start request, and a transmit-byte rewrite, landing in the middle of a running transfer. The bench makes both bus writes a fixed number of cycles after a start, while SCLK is toggling. It then checks that the bit stream and the received byte belong to the first transfer only, and that no extra SCLK edges follow. A divider of 0 and a divider of 1 give an SCLK that toggles on every clock. These are reached by sweeping the divider, and the done time and bit stream are compared with arithmetic expectations. A loop-back device model exposes the register's wrap-around on a 16-bit transfer.

// File: rtl/spim_pkg.sv
package spim_pkg;
  typedef enum logic [2:0] {
    SEL_TX   = 3'd0,
    SEL_RX   = 3'd1,
    SEL_CTRL = 3'd2,
    SEL_STAT = 3'd3,
    SEL_DIV  = 3'd4,
    SEL_CS   = 3'd5
  } spim_sel_e;

  localparam int CTRL_GO_BIT   = 0;
  localparam int CTRL_LEN_LSB  = 8;
  localparam int STAT_DONE_BIT = 0;
  localparam int CS_BIT        = 0;
endpackage

// File: rtl/spim_regs.sv
module spim_regs
  import spim_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8,
  parameter int DIV_W  = 16,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [31:0]       wdata,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              done,
  output logic [31:0]       rdata,
  output logic [DATA_W-1:0] tx_q,
  output logic [DIV_W-1:0]  div_q,
  output logic              cs_q,
  output logic              go,
  output logic [LEN_W-1:0]  go_len
);
  localparam int SEL_W = ADDR_W - 2;

  logic [SEL_W-1:0] sel;
  logic [LEN_W-1:0] len_q;
  logic [31:0]      rd_next;
  logic             unused_bits;

  assign sel         = addr[ADDR_W-1:2];
  assign unused_bits = ^{wdata, addr};

  function automatic logic hit(input logic [SEL_W-1:0] s, input spim_sel_e r);
    return s == SEL_W'(r);
  endfunction

  assign go     = we && hit(sel, SEL_CTRL) && wdata[CTRL_GO_BIT];
  assign go_len = wdata[CTRL_LEN_LSB +: LEN_W];

  always_comb begin
    rd_next = '0;
    if (hit(sel, SEL_TX))   rd_next[DATA_W-1:0] = tx_q;
    if (hit(sel, SEL_RX))   rd_next[DATA_W-1:0] = rx_data;
    if (hit(sel, SEL_CTRL)) rd_next[CTRL_LEN_LSB +: LEN_W] = len_q;
    if (hit(sel, SEL_STAT)) rd_next[STAT_DONE_BIT] = done;
    if (hit(sel, SEL_DIV))  rd_next[DIV_W-1:0] = div_q;
    if (hit(sel, SEL_CS))   rd_next[CS_BIT] = cs_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_q  <= '0;
      div_q <= '0;
      cs_q  <= 1'b0;
      len_q <= '0;
      rdata <= '0;
    end else begin
      if (we) begin
        if (hit(sel, SEL_TX))   tx_q  <= wdata[DATA_W-1:0];
        if (hit(sel, SEL_DIV))  div_q <= wdata[DIV_W-1:0];
        if (hit(sel, SEL_CS))   cs_q  <= wdata[CS_BIT];
        if (hit(sel, SEL_CTRL)) len_q <= go_len;
      end
      rdata <= rd_next;
    end
  end

  AST_CS_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (rst)
    (we && hit(sel, SEL_CS)) |=> (cs_q == $past(wdata[CS_BIT]))); // R9
endmodule

// File: rtl/spim_halfclk.sv
module spim_halfclk #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             run,
  input  logic [DIV_W-1:0] div_in,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lim;

  assign tick = run && (cnt == lim - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      lim <= DIV_W'(1);
    end else if (restart) begin
      cnt <= '0;
      lim <= (div_in == '0) ? DIV_W'(1) : div_in;
    end else if (run) begin
      cnt <= tick ? '0 : cnt + 1'b1;
    end
  end

  AST_PHASE_COUNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt < lim)); // R7
endmodule

// File: rtl/spim_engine.sv
module spim_engine #(
  parameter int DATA_W = 8,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [LEN_W-1:0]  go_len,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              miso,
  input  logic              tick,
  output logic              accept,
  output logic              busy,
  output logic              done,
  output logic              sclk,
  output logic              mosi,
  output logic [DATA_W-1:0] rx_data
);
  logic [DATA_W-1:0] sr;
  logic              capt;
  logic [LEN_W-1:0]  left;

  assign accept = go && !busy && (go_len != '0);
  assign mosi   = sr[DATA_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      sclk    <= 1'b0;
      sr      <= '0;
      capt    <= 1'b0;
      left    <= '0;
      rx_data <= '0;
    end else if (accept) begin
      busy <= 1'b1;
      done <= 1'b0;
      sclk <= 1'b0;
      sr   <= tx_data;
      left <= go_len;
    end else if (busy && tick) begin
      if (!sclk) begin
        sclk <= 1'b1;
        capt <= miso;
      end else begin
        sclk <= 1'b0;
        sr   <= {sr[DATA_W-2:0], capt};
        left <= left - 1'b1;
        if (left == LEN_W'(1)) begin
          busy    <= 1'b0;
          done    <= 1'b1;
          rx_data <= {sr[DATA_W-2:0], capt};
        end
      end
    end
  end

  AST_DONE_CLEARS_ON_START: assert property (@(posedge clk) disable iff (rst)
    accept |=> !done); // R6
  AST_SCLK_LOW_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !sclk); // R4
  AST_MOSI_STEADY_AT_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(sclk) |-> $stable(mosi)); // R4
  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (busy && go && !tick) |=> ($stable(left) && $stable(sr))); // R8
  AST_DONE_AFTER_LAST_EDGE: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> (!busy && !sclk)); // R6
endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8,
  parameter int DIV_W  = 16,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              spi_cs_n,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  logic [DATA_W-1:0] tx_q;
  logic [DATA_W-1:0] rx_q;
  logic [DIV_W-1:0]  div_q;
  logic              cs_q;
  logic              go;
  logic [LEN_W-1:0]  go_len;
  logic              accept;
  logic              busy;
  logic              done;
  logic              tick;

  spim_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIV_W(DIV_W), .LEN_W(LEN_W)) u_regs (
    .clk(clk), .rst(rst), .addr(bus_addr), .we(bus_we), .wdata(bus_wdata),
    .rx_data(rx_q), .done(done), .rdata(bus_rdata), .tx_q(tx_q), .div_q(div_q),
    .cs_q(cs_q), .go(go), .go_len(go_len)
  );

  spim_halfclk #(.DIV_W(DIV_W)) u_halfclk (
    .clk(clk), .rst(rst), .restart(accept), .run(busy), .div_in(div_q), .tick(tick)
  );

  spim_engine #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_engine (
    .clk(clk), .rst(rst), .go(go), .go_len(go_len), .tx_data(tx_q), .miso(spi_miso),
    .tick(tick), .accept(accept), .busy(busy), .done(done), .sclk(spi_sclk),
    .mosi(spi_mosi), .rx_data(rx_q)
  );

  assign spi_cs_n = ~cs_q;
endmodule

// File: tb/spi_byte_master_test.sv
`timescale 1ns/1ps
module spi_byte_master_test;
  localparam logic [4:0] A_TX = 5'h00, A_RX = 5'h04, A_CTRL = 5'h08,
                         A_STAT = 5'h0C, A_DIV = 5'h10, A_CS = 5'h14;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        spi_cs_n, spi_sclk, spi_mosi, spi_miso;

  int tests = 0;
  int fails = 0;

  logic [7:0]  slave_sr;
  logic [7:0]  slave_next = '0;
  logic        slave_ld = 1'b0;
  logic        slave_in = 1'b0;
  logic [31:0] seen;
  int          rises;

  always #10 clk = ~clk;

  spi_byte_master uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  // loop-back device model: sends its byte and takes in what it receives
  assign spi_miso = slave_sr[7];
  always @(negedge spi_sclk or posedge slave_ld)
    if (slave_ld) slave_sr <= slave_next;
    else          slave_sr <= {slave_sr[6:0], slave_in};
  always @(posedge spi_sclk or posedge slave_ld)
    if (slave_ld) begin
      seen  <= '0;
      rises <= 0;
    end else begin
      slave_in <= spi_mosi;
      seen     <= {seen[30:0], spi_mosi};
      rises    <= rises + 1;
    end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic load_slave(input logic [7:0] v);
    slave_next = v;
    slave_ld = 1'b1;
    #1 slave_ld = 1'b0;
  endtask

  task automatic xfer(input logic [7:0] tx, input logic [7:0] sl, input int len, input int dv);
    int n;
    int d_eff;
    logic [31:0] rd, exp_rx, exp_seen;
    d_eff = (dv == 0) ? 1 : dv;
    bus_write(A_DIV, 32'(dv));
    bus_write(A_TX, 32'(tx));
    load_slave(sl);
    @(negedge clk);
    bus_addr = A_CTRL; bus_we = 1'b1; bus_wdata = (32'(len) << 8) | 32'h1;
    @(negedge clk);
    bus_we = 1'b0; bus_addr = A_STAT;
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (n == 1) chk("R6 done clears on start", 32'(bus_rdata[0]), 32'h0);
    end while (!bus_rdata[0] && n < 3000);
    chk("R7 done time 2*D*N", 32'(n), 32'(2 * d_eff * len + 1));
    chk("R4 sclk low after transfer", 32'(spi_sclk), 32'h0);
    if (len <= 8) begin
      exp_rx   = ((32'(tx) << len) | (32'(sl) >> (8 - len))) & 32'hFF;
      exp_seen = 32'(tx) >> (8 - len);
    end else begin
      exp_rx   = 32'(tx);
      exp_seen = {16'h0, tx, sl};
    end
    bus_read(A_RX, rd);
    chk("R5 received byte", rd, exp_rx);
    chk("R4 MSB-first mosi stream", seen, exp_seen);
    chk("R4 sclk rising edge count", 32'(rises), 32'(len));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 cs_n after reset", 32'(spi_cs_n), 32'h1);
    chk("R1 sclk after reset", 32'(spi_sclk), 32'h0);
    bus_read(A_STAT, rd); chk("R1 status after reset", rd, 32'h0);
    bus_read(A_RX, rd);   chk("R1 rx after reset", rd, 32'h0);
    bus_read(A_TX, rd);   chk("R1 tx after reset", rd, 32'h0);
    bus_read(A_DIV, rd);  chk("R1 divider after reset", rd, 32'h0);
    bus_read(A_CTRL, rd); chk("R1 control after reset", rd, 32'h0);
    bus_read(A_CS, rd);   chk("R1 select after reset", rd, 32'h0);

    // R2 field widths and readback
    bus_write(A_TX, 32'h1234_56C3);  bus_read(A_TX, rd);  chk("R2 tx readback", rd, 32'hC3);
    bus_write(A_DIV, 32'hABCD_0107); bus_read(A_DIV, rd); chk("R2 divider readback", rd, 32'h0107);
    // R10 read latency: the address changes and the very next cycle shows it
    @(negedge clk); bus_addr = A_TX;
    @(negedge clk); bus_addr = A_DIV;
    chk("R10 first read cycle", bus_rdata, 32'hC3);
    @(negedge clk);
    chk("R10 second read cycle", bus_rdata, 32'h0107);

    // R9 chip select
    bus_write(A_CS, 32'h1); chk("R9 cs_n low", 32'(spi_cs_n), 32'h0);
    bus_read(A_CS, rd); chk("R9 select readback", rd, 32'h1);
    bus_write(A_CS, 32'h0); chk("R9 cs_n high", 32'(spi_cs_n), 32'h1);
    bus_write(A_CS, 32'h1);

    // R3 control without start bit: no transfer
    load_slave(8'h00);
    bus_write(A_CTRL, 32'h0000_0800);
    repeat (40) @(negedge clk);
    chk("R3 no start bit no edges", 32'(rises), 32'h0);
    bus_read(A_CTRL, rd); chk("R3 control count readback", rd, 32'h0000_0800);

    // R5 R7 sweep over dividers and patterns
    for (int di = 0; di < 5; di++) begin
      for (int p = 0; p < 4; p++) begin
        int dv;
        logic [7:0] tx, sl;
        dv = (di == 4) ? 6 : di;
        tx = 8'(37 * p + 11 * di + 3);
        if (p == 3) tx = 8'hFF;
        if (p == 2) tx = 8'h00;
        sl = 8'(tx * 13 + 91);
        xfer(tx, sl, 8, dv);
      end
    end
    // R5 short lengths and wrap-around
    for (int len = 1; len < 8; len++) xfer(8'hB4 ^ 8'(len), 8'h6D + 8'(len), len, 1);
    xfer(8'hA7, 8'h19, 16, 2);

    // R3 count of zero starts nothing
    load_slave(8'h55);
    bus_write(A_CTRL, 32'h0000_0001);
    repeat (30) @(negedge clk);
    chk("R3 zero count no edges", 32'(rises), 32'h0);
    bus_read(A_STAT, rd); chk("R3 zero count keeps done", rd, 32'h1);

    // R8 start and tx write while busy
    bus_write(A_DIV, 32'h2);
    bus_write(A_TX, 32'hA5);
    load_slave(8'h3C);
    bus_write(A_CTRL, 32'h0000_0801);
    repeat (3) @(negedge clk);
    bus_write(A_TX, 32'hFF);
    bus_write(A_CTRL, 32'h0000_0301);
    repeat (40) @(negedge clk);
    bus_read(A_STAT, rd); chk("R8 first transfer finished", rd, 32'h1);
    bus_read(A_RX, rd);   chk("R8 rx from first transfer", rd, 32'h3C);
    chk("R8 mosi stream of first tx", seen, 32'hA5);
    chk("R8 no extra sclk edges", 32'(rises), 32'h8);
    bus_read(A_TX, rd);   chk("R8 tx write stored", rd, 32'hFF);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule